// File: doc/BRIEF.md
# MII Transmit Nibble-to-Symbol Encoder

This block sits between an Ethernet MAC that speaks a nibble-wide MII-style transmit interface and a serial link framer that expects 5-bit 4B/5B line symbols. It drives a one-cycle ready strobe (`mac_rdy`) to pace the MAC. The MAC answers each strobe by presenting a nibble, an enable and an error flag. The block samples them one cycle later and turns the nibble into the matching line symbol on `sym_out`.

Between frames the block sends Idle. When the MAC raises enable, the block opens the frame with the J and K pair and only then starts requesting nibbles. It closes the frame with T and R. The frame ends when enable is found low in a sample cycle. A short drop of enable at any other time has no effect. The link side can hold the block with `link_stall`. While it is held, the symbol output freezes and no new ready strobe is issued. A nibble already sampled is kept until the stall clears. A minimum run of Idle symbols between frames is set by the `IDLE_GAP` parameter.

Top module: `mii_tx_enc`

## Requirements
- R1: While `rst` is high and after it, until a frame starts, `sym_out` is Idle (11111) and `mac_rdy` is low.
- R2: While no frame is in progress and `mac_en` is low, `sym_out` stays Idle and `mac_rdy` stays low, whatever `mac_d` and `mac_er` carry.
- R3: When `mac_en` is high at an edge in Idle, with the gap met and no stall, J (11000) appears at that edge. K (10001) follows at the next unstalled edge, and `mac_rdy` rises at that same edge.
- R4: `mac_rdy` is never high in two consecutive cycles.
- R5: The nibble is sampled at the end of the cycle that follows a `mac_rdy` cycle. Without a stall its symbol appears at that edge and `mac_rdy` rises again at the same edge, so an unstalled frame requests a nibble every second cycle.
- R6: A sampled nibble with `mac_er` low is encoded as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R7: A sampled nibble with `mac_en` and `mac_er` both high is sent as Halt (00100) instead of its data symbol.
- R8: If `mac_en` is low in a sample cycle, no more nibbles are requested. T (01101) is sent, then R (00111) at the next unstalled edge, then Idle.
- R9: At an edge where `link_stall` is high, `sym_out` keeps its value and `mac_rdy` does not rise.
- R10: A nibble sampled while `link_stall` is high is held. Its symbol (or T) is sent at the first edge with the stall low.
- R11: `mac_en` going low in a cycle that is not a sample cycle does not end the frame, provided it is high again in the sample cycle.
- R12: After R, at least `IDLE_GAP` Idle symbols are sent before the next J. If enable is already high and there is no stall, exactly `IDLE_GAP` are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_en | input | 1 | Frame enable from the MAC |
| mac_d | input | 4 | Data nibble from the MAC |
| mac_er | input | 1 | Error flag for the current nibble |
| link_stall | input | 1 | Link side holds the symbol stream |
| mac_rdy | output | 1 | Nibble request strobe to the MAC |
| sym_out | output | 5 | Current 5-bit line symbol |

## Verification
The sharpest overlap is a link stall that lands in the sample cycle. The same edge must then capture the nibble (or the enable-low that ends the frame) and also refuse to emit a symbol. The bench provokes this with stall patterns of period three and seven that slide across every frame phase. It judges the outcome by the symbol sequence and by checking that each later strobe starts only at an edge without a stall. A second overlap occurs when enable drops between strobes while a stall stretches the gap. These runs are judged by whether T shows up only after the bench has actually ended the frame.

// File: rtl/mii_tx_enc_pkg.sv
package mii_tx_enc_pkg;

  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t SYM_IDLE = 5'b11111;
  localparam sym_t SYM_J    = 5'b11000;
  localparam sym_t SYM_K    = 5'b10001;
  localparam sym_t SYM_T    = 5'b01101;
  localparam sym_t SYM_R    = 5'b00111;
  localparam sym_t SYM_HALT = 5'b00100;

  // sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE,  // Idle on the line, waiting for enable
    ST_JOUT,  // J on the line
    ST_REQ,   // request strobe cycle
    ST_SAMP,  // sample cycle: MAC inputs judged here
    ST_WAIT,  // sampled beat held during a link stall
    ST_TOUT,  // T on the line
    ST_ROUT   // R on the line
  } seq_st_e;

  typedef struct packed {
    logic             en;
    logic             er;
    logic [NIB_W-1:0] d;
  } nib_beat_t;

endpackage

// File: rtl/mii_tx_nib_map.sv
module mii_tx_nib_map
  import mii_tx_enc_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic             err,
  output sym_t             sym
);

  sym_t data_sym;

  always_comb begin
    unique case (nib)
      4'h0: data_sym = 5'b11110;
      4'h1: data_sym = 5'b01001;
      4'h2: data_sym = 5'b10100;
      4'h3: data_sym = 5'b10101;
      4'h4: data_sym = 5'b01010;
      4'h5: data_sym = 5'b01011;
      4'h6: data_sym = 5'b01110;
      4'h7: data_sym = 5'b01111;
      4'h8: data_sym = 5'b10010;
      4'h9: data_sym = 5'b10011;
      4'hA: data_sym = 5'b10110;
      4'hB: data_sym = 5'b10111;
      4'hC: data_sym = 5'b11010;
      4'hD: data_sym = 5'b11011;
      4'hE: data_sym = 5'b11100;
      default: data_sym = 5'b11101;
    endcase
  end

  // an errored nibble is replaced by Halt
  assign sym = err ? SYM_HALT : data_sym;

endmodule

// File: rtl/mii_tx_beat_hold.sv
module mii_tx_beat_hold
  import mii_tx_enc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  nib_beat_t beat_in,
  output nib_beat_t beat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (we) begin
      beat_q <= beat_in;
    end
  end

endmodule

// File: rtl/mii_tx_seq.sv
module mii_tx_seq
  import mii_tx_enc_pkg::*;
#(
  parameter int IDLE_GAP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic stall,
  input  logic mac_en,
  input  logic live_en,
  input  logic held_en,
  input  sym_t enc_sym,
  output logic use_held,
  output logic cap_we,
  output logic rdy_q,
  output sym_t sym_q
);

  localparam int GAP_W = $clog2(IDLE_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(IDLE_GAP);
  localparam logic [GAP_W-1:0] GAP_ONE  = GAP_W'(1);

  seq_st_e          st_q, st_nxt;
  sym_t             sym_nxt;
  logic [GAP_W-1:0] gap_q;
  logic             gap_ok;

  assign gap_ok   = (gap_q >= GAP_FULL);
  assign use_held = (st_q == ST_WAIT);

  always_comb begin
    st_nxt  = st_q;
    sym_nxt = sym_q;
    cap_we  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!stall && mac_en && gap_ok) begin
          st_nxt  = ST_JOUT;
          sym_nxt = SYM_J;
        end
      end
      ST_JOUT: begin
        if (!stall) begin
          st_nxt  = ST_REQ;
          sym_nxt = SYM_K;
        end
      end
      ST_REQ: begin
        st_nxt = ST_SAMP;
      end
      ST_SAMP: begin
        if (stall) begin
          cap_we = 1'b1;
          st_nxt = ST_WAIT;
        end else if (live_en) begin
          st_nxt  = ST_REQ;
          sym_nxt = enc_sym;
        end else begin
          st_nxt  = ST_TOUT;
          sym_nxt = SYM_T;
        end
      end
      ST_WAIT: begin
        if (!stall) begin
          if (held_en) begin
            st_nxt  = ST_REQ;
            sym_nxt = enc_sym;
          end else begin
            st_nxt  = ST_TOUT;
            sym_nxt = SYM_T;
          end
        end
      end
      ST_TOUT: begin
        if (!stall) begin
          st_nxt  = ST_ROUT;
          sym_nxt = SYM_R;
        end
      end
      ST_ROUT: begin
        if (!stall) begin
          st_nxt  = ST_IDLE;
          sym_nxt = SYM_IDLE;
        end
      end
      default: begin
        st_nxt  = ST_IDLE;
        sym_nxt = SYM_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      sym_q <= SYM_IDLE;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      sym_q <= sym_nxt;
      rdy_q <= (st_nxt == ST_REQ);
    end
  end

  // Idle slots sent since R; saturates at the required gap
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GAP_FULL;
    end else if (st_q == ST_ROUT && !stall) begin
      gap_q <= GAP_ONE;
    end else if (st_q == ST_IDLE && !stall && !gap_ok) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R4
  rdy_single_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> !rdy_q);

  // R9
  stall_sym_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(sym_q));

  // R9
  stall_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !rdy_q) |=> !rdy_q);

  // R3
  j_to_k_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_q == SYM_J && !stall) |=> (sym_q == SYM_K && rdy_q));

  // R8
  t_to_r_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_q == SYM_T && !stall) |=> (sym_q == SYM_R && !rdy_q));

  // R8
  r_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_q == SYM_R && !stall) |=> (sym_q == SYM_IDLE));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_q == SYM_IDLE && !mac_en) |=> (sym_q == SYM_IDLE && !rdy_q));

  // R12
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !gap_ok) |=> (sym_q != SYM_J));

endmodule

// File: rtl/mii_tx_enc.sv
module mii_tx_enc
  import mii_tx_enc_pkg::*;
#(
  parameter int IDLE_GAP = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mac_en,
  input  logic [NIB_W-1:0] mac_d,
  input  logic             mac_er,
  input  logic             link_stall,
  output logic             mac_rdy,
  output logic [SYM_W-1:0] sym_out
);

  nib_beat_t live_beat, held_beat, src_beat;
  logic      use_held, cap_we;
  sym_t      enc_sym, sym_q;

  assign live_beat = '{en: mac_en, er: mac_er, d: mac_d};
  assign src_beat  = use_held ? held_beat : live_beat;

  mii_tx_beat_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .we      (cap_we),
    .beat_in (live_beat),
    .beat_q  (held_beat)
  );

  mii_tx_nib_map u_map (
    .nib (src_beat.d),
    .err (src_beat.er),
    .sym (enc_sym)
  );

  mii_tx_seq #(
    .IDLE_GAP (IDLE_GAP)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .stall    (link_stall),
    .mac_en   (mac_en),
    .live_en  (live_beat.en),
    .held_en  (held_beat.en),
    .enc_sym  (enc_sym),
    .use_held (use_held),
    .cap_we   (cap_we),
    .rdy_q    (mac_rdy),
    .sym_q    (sym_q)
  );

  assign sym_out = sym_q;

endmodule

// File: tb/mii_tx_enc_bench.sv
module mii_tx_enc_bench;

  localparam int GAP = 2;
  localparam logic [4:0] S_IDLE = 5'b11111, S_J = 5'b11000, S_K = 5'b10001,
                         S_T = 5'b01101, S_R = 5'b00111, S_HALT = 5'b00100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mac_en = 1'b0, mac_er = 1'b0, link_stall = 1'b0;
  logic [3:0] mac_d = 4'h0;
  logic       mac_rdy;
  logic [4:0] sym_out;
  int         n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mii_tx_enc #(.IDLE_GAP(GAP)) u_mii_tx_enc (
    .clk(clk), .rst(rst), .mac_en(mac_en), .mac_d(mac_d), .mac_er(mac_er),
    .link_stall(link_stall), .mac_rdy(mac_rdy), .sym_out(sym_out)
  );

  function automatic logic [4:0] ref_sym(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100;
      4'h3: return 5'b10101; 4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111; 4'h8: return 5'b10010;
      4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  function automatic logic [3:0] nib(input int f, input int i);
    return 4'((f * 5 + i * 7 + 3) % 16);
  endfunction

  function automatic logic stall_pat(input int mode);
    return mode[0] && ((cyc % 3 == 1) || (cyc % 7 == 0));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // called just after a negedge; leaves at the negedge where Idle follows R
  task automatic run_frame(input int f, input int len, input int mode,
                           input int err_at, input bit first);
    int   rdys = 0, idles = 0, k = 0, last_rdy = -10, guard = 0;
    logic prev_rdy = 1'b0, prev_stall = 1'b0;
    logic [4:0] prev_sym;
    bit   ended = 1'b0, seen_t = 1'b0;
    string tag;
    mac_en = 1'b1; mac_er = 1'b0;
    link_stall = stall_pat(mode);
    forever begin
      @(negedge clk);
      if (sym_out != S_IDLE) break;
      idles++;
      link_stall = stall_pat(mode);
    end
    chk("R3", sym_out, S_J);
    chk("R3", mac_rdy, 0);
    if (!mode[0]) begin
      if (first) chk("R3", idles, 0);
      else chk("R12", idles + 1, GAP);
    end else if (!first) begin
      chk("R12", (idles + 1 >= GAP) ? 1 : 0, 1);
    end
    prev_sym = sym_out;
    while (!seen_t && guard < 4000) begin
      guard++;
      if (k > 0) begin
        if (prev_stall) begin
          chk("R9", sym_out, prev_sym);
          if (!prev_rdy) chk("R9", mac_rdy, 0);
        end
        if (prev_rdy) chk("R4", mac_rdy, 0);
      end
      if (sym_out == S_T && !mac_rdy) begin
        seen_t = 1'b1;
        chk(mode[1] ? "R11" : "R8", ended, 1);
        chk("R8", rdys, len + 1);
      end else if (mac_rdy) begin
        if (rdys == 0) chk("R3", sym_out, S_K);
        else begin
          tag = (rdys - 1 == err_at) ? "R7" : (mode[0] ? "R10" : "R6");
          chk(tag, sym_out, (rdys - 1 == err_at) ? S_HALT : ref_sym(nib(f, rdys - 1)));
          if (!mode[0]) chk("R5", k - last_rdy, 2);
        end
        last_rdy = k;
        if (rdys < len) begin
          mac_en = 1'b1; mac_d = nib(f, rdys); mac_er = (rdys == err_at);
        end else begin
          mac_en = 1'b0; mac_er = 1'b0; mac_d = 4'h0; ended = 1'b1;
        end
        rdys++;
      end else if (prev_rdy) begin
        mac_en = !ended;
      end else if (mode[1] && !ended) begin
        mac_en = 1'b0;
      end
      if (!seen_t) begin
        prev_rdy = mac_rdy; prev_sym = sym_out;
        prev_stall = stall_pat(mode);
        link_stall = prev_stall;
        k++;
        @(negedge clk);
      end
    end
    link_stall = 1'b0;
    mac_en = 1'b0;
    @(negedge clk);
    chk("R8", sym_out, S_R);
    chk("R8", mac_rdy, 0);
    @(negedge clk);
    chk("R8", sym_out, S_IDLE);
  endtask

  initial begin
    int f = 0;
    int lens[5] = '{0, 1, 2, 5, 16};
    repeat (3) @(negedge clk);
    chk("R1", sym_out, S_IDLE);
    chk("R1", mac_rdy, 0);
    rst = 1'b0;
    for (int i = 0; i < 12; i++) begin
      mac_d = 4'(i); mac_er = i[0];
      @(negedge clk);
      chk("R2", sym_out, S_IDLE);
      chk("R2", mac_rdy, 0);
    end
    mac_er = 1'b0;
    for (int li = 0; li < 5; li++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int e = 0; e < 2; e++) begin
          run_frame(f, lens[li], mode,
                    (e == 1 && lens[li] > 0) ? lens[li] / 2 : -1, f == 0);
          f++;
        end
      end
    end
    run_frame(f, 16, 0, 0, 1'b0);  f++;
    run_frame(f, 16, 1, 15, 1'b0); f++;
    run_frame(f, 16, 3, 0, 1'b0);  f++;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (R1..R12 run): got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule